// File: doc/BRIEF.md
# Combined Leading-Count Normalizer

This block takes a binary word and brings its first significant bit up to the most significant position. At the same time it reports how many bit positions it removed. It serves as the normalization step of floating-point and posit datapaths. The count feeds the exponent or regime logic downstream. Rounding and exponent adjustment belong to later stages.

Counting and shifting are not done one after the other. The block has a chain of stages, one for each bit of the count, starting from the largest shift amount. Each stage checks whether the top 2^k bits of the word it receives all equal a reference bit. If they do, it sets count bit k and shifts the word left by 2^k. So a stage never waits for a complete count before it shifts.

A mode input chooses the reference bit. In zero-counting mode the reference is 0. In run-counting mode the reference is the input's own top bit, so a run of ones or a run of zeros is counted, as posit regime decoding needs. The width may be any value, power of two or not. A register can be placed after any subset of the stages, chosen by a parameter mask, and a valid flag travels with the data.

Top module: `lead_norm`

## Requirements
- R1: With `in_mode` = 0 (zero counting) and a non-zero input, `out_count` equals the number of consecutive 0 bits starting from bit WIDTH-1.
- R2: With `in_mode` = 0 and a non-zero input, `out_data` equals the input shifted left by `out_count`, with zeros entering at bit 0, truncated to WIDTH bits. Its bit WIDTH-1 is therefore 1.
- R3: With `in_mode` = 1 (run counting), `out_count` equals the number of consecutive bits, starting from bit WIDTH-1, that equal the input's bit WIDTH-1.
- R4: With `in_mode` = 1 and a count below WIDTH, `out_data` equals the input shifted left by `out_count` with zeros entering at bit 0. Its bit WIDTH-1 is the complement of the input's top bit.
- R5: For a uniform input (all zeros in either mode, or all ones with `in_mode` = 1), `out_count` equals WIDTH and `out_data` is all zeros. `out_count` never exceeds WIDTH, and it is $clog2(WIDTH+1) bits wide for any WIDTH, including non-powers of two.
- R6: The latency from input to output equals the number of set bits in PIPE_MASK among its low $clog2(WIDTH+1) bits. `out_valid` is `in_valid` delayed by that latency, and an input presented with `in_valid` low produces `out_valid` low.
- R7: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 whenever at least one stage is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_mode | input | 1 | 0: count leading zeros, 1: count leading copies of the top bit |
| in_data | input | WIDTH | Word to normalize |
| out_valid | output | 1 | Output word and count are valid |
| out_data | output | WIDTH | Normalized word |
| out_count | output | $clog2(WIDTH+1) | Number of leading positions removed |

## Verification
A stage that takes a wrong decision shows up at the ports in the same result, after the pipeline latency. The count is off by that stage's power of two, and the word sits shifted by the wrong amount, so a stray reference bit or a missed hit is visible in both outputs together. A wrong run limit shows only on uniform or nearly uniform inputs, where the count would pass WIDTH or the data would not be zero. A stage register that loses its valid bit makes `out_valid` disagree with the delayed `in_valid` from then on. All input words of a 10-bit configuration are swept in both modes, with idle gaps in between, so every stage decision is exercised in both directions.

// File: rtl/lcn_pkg.sv
package lcn_pkg;

    typedef enum logic {
        LCN_MODE_ZERO = 1'b0,
        LCN_MODE_RUN  = 1'b1
    } lcn_mode_e;

    // Number of count bits needed to hold the values 0..w
    function automatic int lcn_count_w(input int w);
        return $clog2(w + 1);
    endfunction

    // Cycles of latency given a stage register mask and a stage count
    function automatic int lcn_latency(input int mask, input int stages);
        int n;
        n = 0;
        for (int i = 0; i < stages; i++) begin
            if (((mask >> i) & 1) != 0) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/lcn_seed.sv
module lcn_seed
    import lcn_pkg::*;
#(
    parameter int WIDTH = 26,
    parameter int CW    = lcn_count_w(WIDTH)
) (
    input  logic             in_mode,
    input  logic [WIDTH-1:0] in_data,
    output logic             ref_o,
    output logic [WIDTH-1:0] word_o,
    output logic [CW-1:0]    cnt_o
);

    typedef struct packed {
        logic             rf;
        logic [WIDTH-1:0] word;
        logic [CW-1:0]    cnt;
    } seed_t;

    seed_t seed_d;

    always_comb begin
        seed_d      = '0;
        seed_d.word = in_data;
        seed_d.cnt  = '0;
        if (lcn_mode_e'(in_mode) == LCN_MODE_RUN) begin
            seed_d.rf = in_data[WIDTH-1];
        end else begin
            seed_d.rf = 1'b0;
        end
    end

    assign ref_o  = seed_d.rf;
    assign word_o = seed_d.word;
    assign cnt_o  = seed_d.cnt;

endmodule

// File: rtl/lcn_stage.sv
module lcn_stage
    import lcn_pkg::*;
#(
    parameter int WIDTH = 26,
    parameter int CW    = lcn_count_w(WIDTH),
    parameter int CBIT  = 0,
    parameter bit REG   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic             ref_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic [CW-1:0]    cnt_i,
    output logic             v_o,
    output logic             ref_o,
    output logic [WIDTH-1:0] word_o,
    output logic [CW-1:0]    cnt_o
);

    localparam int SHIFT = 1 << CBIT;

    typedef struct packed {
        logic             v;
        logic             rf;
        logic [WIDTH-1:0] word;
        logic [CW-1:0]    cnt;
    } stage_t;

    stage_t st_d;
    stage_t st_q;
    logic   all_ref;
    logic   room;
    logic   hit;

    always_comb begin
        all_ref = (word_i[WIDTH-1 -: SHIFT] == {SHIFT{ref_i}});
        room    = ((int'(cnt_i) + SHIFT) <= WIDTH);
        hit     = all_ref && room;

        st_d          = '0;
        st_d.v        = v_i;
        st_d.rf       = ref_i;
        st_d.cnt      = cnt_i;
        st_d.cnt[CBIT] = hit;
        if (hit) begin
            st_d.word = word_i << SHIFT;
        end else begin
            st_d.word = word_i;
        end
    end

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            AST_STAGE_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
                v_i |=> v_o) else $error("stage lost valid"); // R6
            AST_STAGE_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                !v_i |=> !v_o) else $error("stage made valid"); // R6
            AST_STAGE_CNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
                v_i |=> (cnt_o >= $past(cnt_i))) else $error("stage count shrank"); // R5
        end else begin : g_pass
            assign st_q = st_d;
        end
    endgenerate

    assign v_o    = st_q.v;
    assign ref_o  = st_q.rf;
    assign word_o = st_q.word;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/lead_norm.sv
module lead_norm
    import lcn_pkg::*;
#(
    parameter int WIDTH     = 26,
    parameter int PIPE_MASK = 0,
    localparam int CW       = lcn_count_w(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_mode,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic [CW-1:0]    out_count
);

    localparam int NSTAGE = CW;
    localparam int LAT    = lcn_latency(PIPE_MASK, NSTAGE);

    logic             v_c    [NSTAGE+1];
    logic             ref_c  [NSTAGE+1];
    logic [WIDTH-1:0] word_c [NSTAGE+1];
    logic [CW-1:0]    cnt_c  [NSTAGE+1];

    assign v_c[0] = in_valid;

    lcn_seed #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_seed (
        .in_mode (in_mode),
        .in_data (in_data),
        .ref_o   (ref_c[0]),
        .word_o  (word_c[0]),
        .cnt_o   (cnt_c[0])
    );

    // Stage i handles the largest remaining shift, 2^(NSTAGE-1-i)
    generate
        for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
            lcn_stage #(
                .WIDTH (WIDTH),
                .CW    (CW),
                .CBIT  (NSTAGE - 1 - i),
                .REG   (((PIPE_MASK >> i) & 1) != 0)
            ) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .v_i    (v_c[i]),
                .ref_i  (ref_c[i]),
                .word_i (word_c[i]),
                .cnt_i  (cnt_c[i]),
                .v_o    (v_c[i+1]),
                .ref_o  (ref_c[i+1]),
                .word_o (word_c[i+1]),
                .cnt_o  (cnt_c[i+1])
            );
        end
    endgenerate

    assign out_valid = v_c[NSTAGE];
    assign out_data  = word_c[NSTAGE];
    assign out_count = cnt_c[NSTAGE];

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_count) <= WIDTH)) else $error("count above width"); // R5
    AST_UNIFORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(out_count) == WIDTH) |-> (out_data == '0)) else $error("uniform data not zero"); // R5
    AST_TOP_BREAKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(out_count) < WIDTH) |-> (out_data[WIDTH-1] != ref_c[NSTAGE])) else $error("msb still matches run"); // R2
    AST_LAT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (LAT == 0) |-> (out_valid == in_valid)) else $error("comb valid mismatch"); // R6

endmodule

// File: tb/lead_norm_tb.sv
module lead_norm_tb;

    localparam int W    = 10;
    localparam int MASK = 5;   // stages 0 and 2 registered
    localparam int LAT  = 2;
    localparam int CW   = 4;

    logic          clk;
    logic          rst_n;
    logic          in_valid;
    logic          in_mode;
    logic [W-1:0]  in_data;
    logic          out_valid;
    logic [W-1:0]  out_data;
    logic [CW-1:0] out_count;

    int checks;
    int fails;
    bit done;

    logic         hv [LAT];
    logic [W-1:0] hd [LAT];
    int           hc [LAT];
    logic         hm [LAT];

    lead_norm #(
        .WIDTH     (W),
        .PIPE_MASK (MASK)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_count (out_count)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int ref_count(input logic [W-1:0] d, input logic m);
        logic r;
        int   c;
        bit   stop;
        r    = m ? d[W-1] : 1'b0;
        c    = 0;
        stop = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stop && d[i] == r) c++;
            else stop = 1;
        end
        return c;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check_out();
        logic [W-1:0] ed;
        checks++;
        if (out_valid !== hv[LAT-1]) begin
            fails++;
            $display("FAIL R6 out_valid actual %0b expected %0b", out_valid, hv[LAT-1]);
        end
        if (hv[LAT-1]) begin
            ed = (hc[LAT-1] >= W) ? '0 : (hd[LAT-1] << hc[LAT-1]);
            checks++;
            if (int'(out_count) != hc[LAT-1]) begin
                fails++;
                if (hc[LAT-1] == W)
                    $display("FAIL R5 count in=%h actual %0d expected %0d", hd[LAT-1], out_count, hc[LAT-1]);
                else if (hm[LAT-1])
                    $display("FAIL R3 count in=%h actual %0d expected %0d", hd[LAT-1], out_count, hc[LAT-1]);
                else
                    $display("FAIL R1 count in=%h actual %0d expected %0d", hd[LAT-1], out_count, hc[LAT-1]);
            end
            checks++;
            if (out_data !== ed) begin
                fails++;
                if (hc[LAT-1] == W)
                    $display("FAIL R5 data in=%h actual %h expected %h", hd[LAT-1], out_data, ed);
                else if (hm[LAT-1])
                    $display("FAIL R4 data in=%h actual %h expected %h", hd[LAT-1], out_data, ed);
                else
                    $display("FAIL R2 data in=%h actual %h expected %h", hd[LAT-1], out_data, ed);
            end
        end
    endtask

    task automatic step(input logic v, input logic m, input logic [W-1:0] d);
        @(negedge clk);
        check_out();
        for (int i = LAT - 1; i > 0; i--) begin
            hv[i] = hv[i-1];
            hd[i] = hd[i-1];
            hc[i] = hc[i-1];
            hm[i] = hm[i-1];
        end
        hv[0]    = v;
        hd[0]    = d;
        hm[0]    = m;
        hc[0]    = ref_count(d, m);
        in_valid = v;
        in_mode  = m;
        in_data  = d;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        checks   = 0;
        fails    = 0;
        done     = 0;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_mode  = 1'b0;
        in_data  = '0;
        for (int i = 0; i < LAT; i++) begin
            hv[i] = 0; hd[i] = '0; hc[i] = 0; hm[i] = 0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R7 out_valid in reset actual %0b expected 0", out_valid);
        end
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R7 out_valid after reset actual %0b expected 0", out_valid);
        end
        // R1 R2 R3 R4 R5: every word in both modes, idle gaps with junk data (R6)
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < (1 << W); d++) begin
                step(1'b1, m[0], d[W-1:0]);
                if ((d % 7) == 3) step(1'b0, m[0], ~d[W-1:0]);
            end
        end
        // R5 explicit uniform words
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b1, '1);
        step(1'b1, 1'b1, '0);
        step(1'b1, 1'b0, '1);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0);
        finish_run();
    end

endmodule